// File: doc/BRIEF.md
# Multiprocessor Start and Pause Controller

This block decides which of a cluster's processors may run, and it is how one processor starts another. Any processor can access it through a small register interface. Two 64-bit registers hold the program address and the stack address that a core receives when it is started. Writing a CPU index to the start register sends that core a one-cycle start strobe, together with a snapshot of both addresses. It also raises the core's run-enable bit.

A second command stops every core except the one named. A third command re-enables a single named core. Two read-only registers return the caller's own index and the size of the cluster.

Start commands pass through a two-state launch machine. In `LS_IDLE` no strobe is driven. An accepted start write moves the machine to `LS_LAUNCH`. `LS_LAUNCH` drives the strobe for one cycle. It then returns to `LS_IDLE`, or stays in `LS_LAUNCH` if another accepted start write arrives in that cycle. In that case the strobe moves to the new target.

Top module: `mp_run_ctrl`

## Requirements
- R1: After reset `run_en` holds only bit 0 set. The program address register holds `RESET_PC` and the stack address register holds `RESET_SP`.
- R2: A write to register select 3 (program address) or 4 (stack address) stores `req_wdata`. When `req_half` is 1, bits 63:32 are zero and bit 31 is one, the stored value has bits 63:32 set to ones. Every other value is stored exactly as written.
- R3: A write of index k < N_CPU to register select 2 (start) gives the following, in the next cycle:
  - `start_pulse` has only bit k set, for one cycle;
  - `start_pc` and `start_sp` equal the address registers as they were when the write was accepted;
  - `run_en[k]` is 1.
- R4: A start write whose 64-bit value is N_CPU or more has no effect: there is no strobe and `run_en` does not change.
- R5: A write of value k to register select 5 (pause) clears every `run_en` bit except bit k, which keeps its value. A value of N_CPU or more clears all bits.
- R6: A write of value k to register select 6 (resume) sets `run_en[k]` when k < N_CPU. Otherwise it has no effect.
- R7: A read returns its data on `rd_data` one cycle after the request:
  - register select 0 returns `req_cpu`;
  - register select 1 returns N_CPU;
  - every other register select returns zero;
  - `rd_data` is zero in any cycle that follows no read.
- R8: Writes to register select 0 or 1 change neither `run_en` nor `start_pulse`.
- R9: The launch machine moves from `LS_IDLE` to `LS_LAUNCH` on an accepted start write. It leaves `LS_LAUNCH` for `LS_IDLE` after one cycle unless a new accepted start write arrives in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Register access in this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_half | input | 1 | 1 = 32-bit write (sign extension rule of R2) |
| req_sel | input | 3 | Register select |
| req_cpu | input | IDX_W | Index of the requesting processor |
| req_wdata | input | 64 | Write data |
| rd_data | output | 64 | Read data, one cycle after the request |
| run_en | output | N_CPU | Per-core run enable |
| start_pulse | output | N_CPU | Per-core one-cycle start strobe |
| start_pc | output | 64 | Program address sent with the strobe |
| start_sp | output | 64 | Stack address sent with the strobe |

## Verification
A run flag that is wrong shows on `run_en` in the cycle after the command that caused it. Because the bench compares every cycle, it cannot stay hidden. A launch machine stuck in `LS_LAUNCH` shows as a strobe lasting two cycles. A wrong address register only shows at the next start strobe, so every address write is followed by a start to expose it.

// File: rtl/mp_ctrl_pkg.sv
package mp_ctrl_pkg;

    localparam int WORD_W = 64;

    typedef enum logic [2:0] {
        SEL_ID     = 3'd0,
        SEL_COUNT  = 3'd1,
        SEL_START  = 3'd2,
        SEL_PC     = 3'd3,
        SEL_SP     = 3'd4,
        SEL_PAUSE  = 3'd5,
        SEL_RESUME = 3'd6,
        SEL_SPARE  = 3'd7
    } reg_sel_e;

    typedef enum logic {
        LS_IDLE   = 1'b0,
        LS_LAUNCH = 1'b1
    } launch_state_e;

    // A 32-bit write with a clear upper half and bit 31 set is widened with ones.
    function automatic logic [WORD_W-1:0] widen_word(input logic half,
                                                     input logic [WORD_W-1:0] d);
        if (half && (d[WORD_W-1:32] == '0) && d[31])
            return {{(WORD_W-32){1'b1}}, d[31:0]};
        return d;
    endfunction

endpackage

// File: rtl/mp_wide_reg.sv
module mp_wide_reg
    import mp_ctrl_pkg::*;
#(
    parameter logic [WORD_W-1:0] RST_VAL = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic              half,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] q
);

    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= RST_VAL;
        else if (we)
            q <= widen_word(half, wdata);
    end

    // R2
    sext_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && half && wdata[WORD_W-1:32] == '0 && wdata[31]) |=> (q[WORD_W-1:32] == '1));

    // R2
    keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(q));

endmodule

// File: rtl/mp_run_flags.sv
module mp_run_flags #(
    parameter int N_CPU = 4,
    parameter int IDX_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_go,
    input  logic             pause_go,
    input  logic             resume_go,
    input  logic             idx_ok,
    input  logic [IDX_W-1:0] idx,
    output logic [N_CPU-1:0] run_q
);

    for (genvar i = 0; i < N_CPU; i++) begin : g_flag
        logic named;
        assign named = idx_ok && (idx == IDX_W'(i));

        always_ff @(posedge clk) begin
            if (!rst_n)
                run_q[i] <= (i == 0);
            else if ((start_go || resume_go) && named)
                run_q[i] <= 1'b1;
            else if (pause_go && !named)
                run_q[i] <= 1'b0;
        end
    end

    // R3
    start_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_go |=> run_q[$past(idx)]);

    // R5
    pause_leaves_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pause_go |=> ($countones(run_q) <= 1));

    // R6
    resume_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (resume_go && !idx_ok) |=> $stable(run_q));

endmodule

// File: rtl/mp_launch_fsm.sv
module mp_launch_fsm
    import mp_ctrl_pkg::*;
#(
    parameter int N_CPU = 4,
    parameter int IDX_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic [IDX_W-1:0]  go_idx,
    input  logic [WORD_W-1:0] pc_in,
    input  logic [WORD_W-1:0] sp_in,
    output logic [N_CPU-1:0]  pulse,
    output logic [WORD_W-1:0] pc_out,
    output logic [WORD_W-1:0] sp_out
);

    launch_state_e     state_q, state_d;
    logic [IDX_W-1:0]  tgt_q;
    logic [WORD_W-1:0] pc_snap, sp_snap;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LS_IDLE:   if (go) state_d = LS_LAUNCH;
            LS_LAUNCH: if (!go) state_d = LS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= LS_IDLE;
            tgt_q   <= '0;
            pc_snap <= '0;
            sp_snap <= '0;
        end else begin
            state_q <= state_d;
            if (go) begin
                tgt_q   <= go_idx;
                pc_snap <= pc_in;
                sp_snap <= sp_in;
            end
        end
    end

    always_comb begin
        pulse = '0;
        unique case (state_q)
            LS_IDLE:   pulse = '0;
            LS_LAUNCH: pulse[tgt_q] = 1'b1;
        endcase
    end

    assign pc_out = pc_snap;
    assign sp_out = sp_snap;

    // R9
    launch_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LS_LAUNCH && !go) |=> (state_q == LS_IDLE));

    // R3
    pulse_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pulse));

    // R3
    snap_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        go |=> (pc_out == $past(pc_in) && sp_out == $past(sp_in)));

endmodule

// File: rtl/mp_run_ctrl.sv
module mp_run_ctrl
    import mp_ctrl_pkg::*;
#(
    parameter int                N_CPU    = 4,
    parameter int                IDX_W    = (N_CPU > 1) ? $clog2(N_CPU) : 1,
    parameter logic [WORD_W-1:0] RESET_PC = 64'hFFFF_FFFF_BFC0_0000,
    parameter logic [WORD_W-1:0] RESET_SP = 64'hFFFF_FFFF_A000_7F00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_half,
    input  logic [2:0]        req_sel,
    input  logic [IDX_W-1:0]  req_cpu,
    input  logic [WORD_W-1:0] req_wdata,
    output logic [WORD_W-1:0] rd_data,
    output logic [N_CPU-1:0]  run_en,
    output logic [N_CPU-1:0]  start_pulse,
    output logic [WORD_W-1:0] start_pc,
    output logic [WORD_W-1:0] start_sp
);

    reg_sel_e          sel;
    logic              wr, rd, idx_ok;
    logic              start_go, pause_go, resume_go, pc_we, sp_we;
    logic [WORD_W-1:0] pc_q, sp_q, rd_q;

    assign sel       = reg_sel_e'(req_sel);
    assign wr        = req_valid && req_write;
    assign rd        = req_valid && !req_write;
    assign idx_ok    = req_wdata < WORD_W'(N_CPU);
    assign start_go  = wr && (sel == SEL_START) && idx_ok;
    assign pause_go  = wr && (sel == SEL_PAUSE);
    assign resume_go = wr && (sel == SEL_RESUME);
    assign pc_we     = wr && (sel == SEL_PC);
    assign sp_we     = wr && (sel == SEL_SP);

    mp_wide_reg #(.RST_VAL(RESET_PC)) u_pc (
        .clk(clk), .rst_n(rst_n), .we(pc_we), .half(req_half),
        .wdata(req_wdata), .q(pc_q)
    );

    mp_wide_reg #(.RST_VAL(RESET_SP)) u_sp (
        .clk(clk), .rst_n(rst_n), .we(sp_we), .half(req_half),
        .wdata(req_wdata), .q(sp_q)
    );

    mp_run_flags #(.N_CPU(N_CPU), .IDX_W(IDX_W)) u_flags (
        .clk(clk), .rst_n(rst_n), .start_go(start_go), .pause_go(pause_go),
        .resume_go(resume_go), .idx_ok(idx_ok), .idx(req_wdata[IDX_W-1:0]),
        .run_q(run_en)
    );

    mp_launch_fsm #(.N_CPU(N_CPU), .IDX_W(IDX_W)) u_launch (
        .clk(clk), .rst_n(rst_n), .go(start_go), .go_idx(req_wdata[IDX_W-1:0]),
        .pc_in(pc_q), .sp_in(sp_q), .pulse(start_pulse),
        .pc_out(start_pc), .sp_out(start_sp)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_q <= '0;
        else if (rd) begin
            unique case (sel)
                SEL_ID:    rd_q <= WORD_W'(req_cpu);
                SEL_COUNT: rd_q <= WORD_W'(N_CPU);
                default:   rd_q <= '0;
            endcase
        end else
            rd_q <= '0;
    end

    assign rd_data = rd_q;

    // R7
    count_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && sel == SEL_COUNT) |=> (rd_data == WORD_W'(N_CPU)));

    // R7
    idle_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd |=> (rd_data == '0));

    // R8
    ro_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && (sel == SEL_ID || sel == SEL_COUNT)) |=> $stable(run_en));

endmodule

// File: tb/sim_mp_run_ctrl.sv
`timescale 1ns/1ps
module sim_mp_run_ctrl;

    localparam int NC = 4;
    localparam logic [63:0] DPC = 64'hFFFF_FFFF_BFC0_0000;
    localparam logic [63:0] DSP = 64'hFFFF_FFFF_A000_7F00;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0, req_half = 1'b0;
    logic [2:0]  req_sel = '0;
    logic [1:0]  req_cpu = '0;
    logic [63:0] req_wdata = '0;
    logic [63:0] rd_data, start_pc, start_sp;
    logic [NC-1:0] run_en, start_pulse;

    int checks = 0;
    int failures = 0;

    // behavioural reference state
    bit [NC-1:0] m_run;
    bit [NC-1:0] m_pulse;
    bit [63:0]   m_pc, m_sp, m_opc, m_osp, m_rd;

    always #2.5 clk = ~clk;

    mp_run_ctrl #(.N_CPU(NC), .RESET_PC(DPC), .RESET_SP(DSP)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_half(req_half), .req_sel(req_sel), .req_cpu(req_cpu),
        .req_wdata(req_wdata), .rd_data(rd_data), .run_en(run_en),
        .start_pulse(start_pulse), .start_pc(start_pc), .start_sp(start_sp)
    );

    task automatic check(input string tag, input string what,
                         input bit [63:0] act, input bit [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic bit [63:0] widen(input bit half, input bit [63:0] d);
        if (half && d[63:32] == 0 && d[31]) return d | 64'hFFFF_FFFF_0000_0000;
        return d;
    endfunction

    // one clock: drive at negedge, update model at posedge, compare at next negedge
    task automatic step(input bit v, input bit w, input bit half, input int sel,
                        input int cpu, input bit [63:0] d, input string tag);
        req_valid = v; req_write = w; req_half = half;
        req_sel = 3'(sel); req_cpu = 2'(cpu); req_wdata = d;
        @(posedge clk);
        m_pulse = '0;
        m_rd = '0;
        if (v && w) begin
            case (sel)
                2: if (d < NC) begin
                       m_pulse[d[1:0]] = 1'b1;
                       m_opc = m_pc; m_osp = m_sp;
                       m_run[d[1:0]] = 1'b1;
                   end
                3: m_pc = widen(half, d);
                4: m_sp = widen(half, d);
                5: for (int i = 0; i < NC; i++)
                       if (!(d < NC && d == i)) m_run[i] = 1'b0;
                6: if (d < NC) m_run[d[1:0]] = 1'b1;
                default: ;
            endcase
        end else if (v) begin
            if (sel == 0) m_rd = 64'(cpu);
            else if (sel == 1) m_rd = NC;
        end
        @(negedge clk);
        req_valid = 1'b0;
        check(tag, "run_en", 64'(run_en), 64'(m_run));
        check(tag, "start_pulse", 64'(start_pulse), 64'(m_pulse));
        check(tag, "rd_data", rd_data, m_rd);
        if (m_pulse != 0) begin
            check(tag, "start_pc", start_pc, m_opc);
            check(tag, "start_sp", start_sp, m_osp);
        end
    endtask

    initial begin
        #(5.0 * 20000);
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        m_run = 4'b0001; m_pulse = '0; m_pc = DPC; m_sp = DSP; m_rd = '0;
        m_opc = '0; m_osp = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1", "run_en reset", 64'(run_en), 64'h1);
        check("R1", "start_pulse reset", 64'(start_pulse), 64'h0);
        check("R1", "rd_data reset", rd_data, 64'h0);
        // R1 default addresses seen through a start, R3 strobe
        step(1, 1, 0, 2, 0, 64'd1, "R1");
        step(0, 0, 0, 0, 0, 64'd0, "R3");
        // R2 address writes in several widths
        step(1, 1, 0, 3, 0, 64'h1234_5678_9ABC_DEF0, "R2");
        step(1, 1, 1, 4, 0, 64'h0000_0000_8000_1000, "R2");
        step(1, 1, 0, 2, 0, 64'd3, "R3");
        step(1, 1, 1, 3, 0, 64'h0000_0000_7FFF_0000, "R2");
        step(1, 1, 1, 4, 0, 64'h0000_0001_8000_0004, "R2");
        step(1, 1, 0, 2, 0, 64'd2, "R3");
        step(1, 1, 0, 3, 0, 64'h0000_0000_8000_0040, "R2");
        step(1, 1, 0, 2, 0, 64'd1, "R2");
        step(0, 0, 0, 0, 0, 64'd0, "R3");
        // R4 out-of-range starts
        step(1, 1, 0, 2, 0, 64'd4, "R4");
        step(1, 1, 0, 2, 0, 64'hFFFF_FFFF_FFFF_FFFF, "R4");
        // R5 pause
        step(1, 1, 0, 5, 0, 64'd2, "R5");
        step(1, 1, 0, 5, 0, 64'd1, "R5");
        step(1, 1, 0, 6, 0, 64'd0, "R6");
        step(1, 1, 0, 6, 0, 64'd3, "R6");
        step(1, 1, 0, 5, 0, 64'd9, "R5");
        // R6 resume
        step(1, 1, 0, 6, 0, 64'd9, "R6");
        step(1, 1, 0, 6, 0, 64'd2, "R6");
        step(1, 1, 0, 6, 0, 64'd2, "R6");
        step(1, 1, 0, 6, 0, 64'h1_0000_0001, "R6");
        // R7 reads
        step(1, 0, 0, 0, 2, 64'd0, "R7");
        step(1, 0, 0, 0, 3, 64'd0, "R7");
        step(1, 0, 0, 1, 1, 64'd0, "R7");
        step(1, 0, 0, 3, 1, 64'd0, "R7");
        step(1, 0, 0, 6, 1, 64'd0, "R7");
        step(0, 0, 0, 1, 1, 64'd0, "R7");
        // R8 writes to read-only registers
        step(1, 1, 0, 0, 0, 64'd3, "R8");
        step(1, 1, 0, 1, 0, 64'd1, "R8");
        // R9 back-to-back starts keep the launch state
        step(1, 1, 0, 5, 0, 64'd0, "R9");
        step(1, 1, 0, 2, 0, 64'd1, "R9");
        step(1, 1, 0, 2, 0, 64'd3, "R9");
        step(0, 0, 0, 0, 0, 64'd0, "R9");
        step(0, 0, 0, 0, 0, 64'd0, "R9");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule